// File: doc/BRIEF.md
# Dual-Bank Burst Read Sequencer

This block is the synchronous read front end of a two-bank memory with 21-bit word addresses and 16-bit words. In burst mode it loads a start address on a rising clock edge and then advances an internal word counter once per clock. Each counter value goes to a synchronous array port. The array's word comes back on the data output two clock edges after the address was loaded into the counter. In asynchronous mode the applied address is loaded on every edge while the chip is enabled, which gives random access through the same path.

The address space has two banks. The low bank spans 0x000000 to 0x07FFFF and the high bank spans 0x080000 to 0x1FFFFF. A burst runs across the bank boundary without a pause. Past the last address of the high bank, the counter wraps to address 0. Each bank has a busy flag that marks a program or erase operation in progress. Any word addressed in a busy bank is replaced by the supplied status word. The counter keeps advancing while this happens.

Top module: `flash_burst_reader`

## Requirements
- R1: In burst mode (`burst_mode`=1), a rising edge with `ce_n`=0 and `adv_n`=0 loads `addr` into the counter, and `arr_addr` shows that address after the edge.
- R2: While a burst is active, with `ce_n`=0 and `adv_n`=1, `arr_addr` increases by one on every rising edge. `addr` has no effect during this time.
- R3: The low bank is 0x000000–0x07FFFF and the high bank is 0x080000–0x1FFFFF. A burst passes from 0x07FFFF to 0x080000 with no missing or repeated word.
- R4: After 0x1FFFFF, the counter moves to 0x000000.
- R5: A word whose address lies in a bank with a set `bank_busy` bit (bit 0 = low bank, bit 1 = high bank) is returned as `status_word` in place of array data. Counting continues unchanged.
- R6: For each word, the busy flags are sampled on the edge after that word's address appears on `arr_addr`. A bank that becomes busy or idle during a burst therefore switches between status and array data from the next word on.
- R7: Suppose an address appears on `arr_addr` after edge k. The array returns data one cycle later. The matching word is on `dout`, with `dvalid`=1, after edge k+2.
- R8: After any edge where `ce_n` or `oe_n` is high, `dout` is 0 and `dvalid` is 0.
- R9: A high `ce_n` ends the burst. No valid word follows until a new address is loaded.
- R10: In asynchronous mode (`burst_mode`=0), every edge with `ce_n`=0 loads `addr` regardless of `adv_n`. The word follows with the R7 latency.
- R11: After reset, `arr_addr`, `dout` and `dvalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | 1 = burst mode, 0 = asynchronous random access |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address load strobe, active low (burst mode) |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 21 | Applied word address |
| bank_busy | input | 2 | Per-bank program/erase busy flags |
| arr_rdata | input | 16 | Array read data, one cycle after `arr_addr` |
| status_word | input | 16 | Status value substituted for busy-bank words |
| arr_addr | output | 21 | Address sent to the array |
| dout | output | 16 | Output word |
| dvalid | output | 1 | `dout` carries a valid word |

## Verification
Bursts with random start addresses and lengths are run with busy flags that change randomly on every word. This separates a status choice made per word from one made once per burst, and it also shows the busy sample happening in the right cycle. Directed bursts cover the following:
- A burst starting at 0x07FFFD with only the high bank busy shows a correct bank decode and an unbroken boundary crossing.
- A burst starting at 0x1FFFFE shows the wrap to address 0.
- A burst that starts in a busy bank shows status data while the counter keeps advancing.
- A one-word `oe_n` pulse and a `ce_n` pulse separate output gating from ending the burst.
- Random asynchronous addresses show that the address is loaded on every edge and that `adv_n` is ignored in this mode.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;
  typedef struct packed {
    logic valid;
    logic use_status;
  } rd_tag_t;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst_mode,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cnt_q,
  output logic          addr_valid_q,
  output logic          burst_on_q
);
  // Counter wraps naturally at 2**AW, giving top-to-bottom wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      addr_valid_q <= 1'b0;
      burst_on_q   <= 1'b0;
    end else if (ce_n) begin
      addr_valid_q <= 1'b0;
      burst_on_q   <= 1'b0;
    end else if (!burst_mode) begin
      cnt_q        <= addr;
      addr_valid_q <= 1'b1;
      burst_on_q   <= 1'b0;
    end else if (!adv_n) begin
      cnt_q        <= addr;
      addr_valid_q <= 1'b1;
      burst_on_q   <= 1'b1;
    end else if (burst_on_q) begin
      cnt_q        <= cnt_q + 1'b1;
      addr_valid_q <= 1'b1;
    end else begin
      addr_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_tag_stage.sv
module bank_tag_stage
  import flash_burst_pkg::*;
#(
  parameter int          AW         = 21,
  parameter int unsigned BANK0_LAST = 'h7FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce_n,
  input  logic [AW-1:0]        arr_addr,
  input  logic                 addr_valid,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output rd_tag_t              tag_q
);
  localparam logic [AW-1:0] LO_LAST = AW'(BANK0_LAST);

  logic bank_idx;
  assign bank_idx = (arr_addr > LO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q.valid      <= addr_valid && !ce_n;
      tag_q.use_status <= bank_busy[bank_idx];
    end
  end
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage
  import flash_burst_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  rd_tag_t       tag,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] status_word,
  output logic [DW-1:0] dout_q,
  output logic          dvalid_q
);
  logic drive;
  assign drive = tag.valid && !ce_n && !oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dvalid_q <= drive;
      dout_q   <= drive ? (tag.use_status ? status_word : arr_rdata) : '0;
    end
  end
endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
  import flash_burst_pkg::*;
#(
  parameter int          AW         = 21,
  parameter int          DW         = 16,
  parameter int unsigned BANK0_LAST = 'h7FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 burst_mode,
  input  logic                 ce_n,
  input  logic                 adv_n,
  input  logic                 oe_n,
  input  logic [AW-1:0]        addr,
  input  logic [NUM_BANKS-1:0] bank_busy,
  input  logic [DW-1:0]        arr_rdata,
  input  logic [DW-1:0]        status_word,
  output logic [AW-1:0]        arr_addr,
  output logic [DW-1:0]        dout,
  output logic                 dvalid
);
  logic    addr_valid;
  logic    burst_on;
  rd_tag_t tag_q;
  logic    tag_valid;

  burst_addr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .burst_mode(burst_mode), .ce_n(ce_n),
    .adv_n(adv_n), .addr(addr), .cnt_q(arr_addr),
    .addr_valid_q(addr_valid), .burst_on_q(burst_on)
  );

  bank_tag_stage #(.AW(AW), .BANK0_LAST(BANK0_LAST)) u_tag (
    .clk(clk), .rst(rst), .ce_n(ce_n), .arr_addr(arr_addr),
    .addr_valid(addr_valid), .bank_busy(bank_busy), .tag_q(tag_q)
  );

  assign tag_valid = tag_q.valid;

  burst_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .tag(tag_q),
    .arr_rdata(arr_rdata), .status_word(status_word),
    .dout_q(dout), .dvalid_q(dvalid)
  );
endmodule

// File: rtl/flash_burst_reader_chk.sv
module flash_burst_reader_chk #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          burst_mode,
  input logic          ce_n,
  input logic          adv_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] arr_addr,
  input logic [DW-1:0] dout,
  input logic          dvalid,
  input logic          burst_on,
  input logic          tag_valid
);
  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    (burst_mode && !ce_n && !adv_n) |=> (arr_addr == $past(addr)));

  // R4 wrap is covered by the modular increment checked here
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (burst_mode && !ce_n && adv_n && burst_on) |=> (arr_addr == $past(arr_addr) + 1'b1));

  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> (dout == '0 && !dvalid));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid) |-> $past(tag_valid));

  assert_end_R9: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !burst_on);

  assert_async_R10: assert property (@(posedge clk) disable iff (rst)
    (!burst_mode && !ce_n) |=> (arr_addr == $past(addr) && !burst_on));
endmodule

bind flash_burst_reader flash_burst_reader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .burst_mode(burst_mode), .ce_n(ce_n), .adv_n(adv_n),
  .oe_n(oe_n), .addr(addr), .arr_addr(arr_addr), .dout(dout), .dvalid(dvalid),
  .burst_on(burst_on), .tag_valid(tag_valid)
);

// File: tb/tb_flash_burst_reader.sv
module tb_flash_burst_reader;
  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          burst_mode = 1'b0;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    bank_busy = '0;
  logic [DW-1:0] arr_rdata = '0;
  logic [DW-1:0] status_word = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] dout;
  logic          dvalid;

  int n_checks = 0;
  int n_fail   = 0;
  logic [AW-1:0] waddr [0:31];
  logic [1:0]    wbusy [0:31];

  always #2.5 clk = ~clk;

  flash_burst_reader dut (
    .clk(clk), .rst(rst), .burst_mode(burst_mode), .ce_n(ce_n), .adv_n(adv_n),
    .oe_n(oe_n), .addr(addr), .bank_busy(bank_busy), .arr_rdata(arr_rdata),
    .status_word(status_word), .arr_addr(arr_addr), .dout(dout), .dvalid(dvalid)
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return a[15:0] ^ {a[20:16], a[20:16], a[20:16], 1'b1};
  endfunction

  function automatic logic bank_of(input logic [AW-1:0] a);
    return a >= 21'h080000;
  endfunction

  // one-cycle array model
  always_ff @(posedge clk) arr_rdata <= memf(arr_addr);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode: 1 burst, 0 async. busy_kind: 0 fixed, 1 random, 2 idle then both busy
  task automatic run_seq(input logic mode, input logic [AW-1:0] s, input int len,
                         input int busy_kind, input logic [1:0] busy_fix,
                         input int gap, input string req);
    logic [DW-1:0] st;
    logic [DW-1:0] exp_d;
    logic          exp_v;
    st = DW'($urandom);
    waddr[0] = s;
    for (int i = 1; i < len + 1; i++)
      waddr[i] = mode ? waddr[i-1] + 1'b1 : AW'($urandom);
    @(negedge clk);
    status_word = st; burst_mode = mode; ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = s;
    @(posedge clk);
    for (int m = 0; m < len + 2; m++) begin
      @(negedge clk);
      if (mode) begin
        adv_n = 1'b1;
        addr  = AW'($urandom);
      end else begin
        adv_n = m[0];
        addr  = waddr[m+1];
      end
      if (m >= 2) begin
        exp_v = !(gap == m - 2);
        exp_d = !exp_v ? '0 :
                (wbusy[m-2][bank_of(waddr[m-2])] ? st : memf(waddr[m-2]));
        check(dout == exp_d && dvalid == exp_v, req, {15'd0, dvalid, dout}, {15'd0, exp_v, exp_d});
      end
      if (m < len)
        check(arr_addr == waddr[m], {req, " addr"}, 32'(arr_addr), 32'(waddr[m]));
      if (m == gap + 1) oe_n = 1'b1;
      if (m == gap + 2) oe_n = 1'b0;
      if (m < len) begin
        case (busy_kind)
          0: bank_busy = busy_fix;
          1: bank_busy = 2'($urandom);
          default: bank_busy = (m < len / 2) ? 2'b00 : 2'b11;
        endcase
        wbusy[m] = bank_busy;
      end
    end
    @(negedge clk);
    ce_n = 1'b1; bank_busy = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(arr_addr == '0 && dout == '0 && !dvalid, "R11", {arr_addr, dvalid}, 32'd0);

    // R1 R2 R7 basic burst, all idle
    run_seq(1'b1, 21'h000123, 8, 0, 2'b00, -10, "R1 R2 R7");
    // R3 boundary crossing, high bank busy
    run_seq(1'b1, 21'h07FFFD, 6, 0, 2'b10, -10, "R3 R5");
    // R4 wrap at top
    run_seq(1'b1, 21'h1FFFFE, 5, 0, 2'b00, -10, "R4");
    // R5 start in busy low bank
    run_seq(1'b1, 21'h000010, 5, 0, 2'b01, -10, "R5");
    // R6 busy changes mid burst
    run_seq(1'b1, 21'h0A0000, 8, 2, 2'b00, -10, "R6");
    // R8 one-word oe_n gap
    run_seq(1'b1, 21'h012345, 6, 0, 2'b00, 2, "R8");
    // R10 async random access
    run_seq(1'b0, 21'h155555, 10, 1, 2'b00, -10, "R10");

    // R9 ce_n pulse ends burst
    @(negedge clk);
    burst_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 21'h000400;
    @(negedge clk); adv_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    check(!dvalid && dout == '0, "R9 R8 ce high", {15'd0, dvalid, dout}, 32'd0);
    ce_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!dvalid, "R9 no resume", 32'(dvalid), 32'd0);
    end
    ce_n = 1'b1;
    @(negedge clk);

    // random bursts, R5 R6 with random busy flags
    for (int b = 0; b < 25; b++)
      run_seq(1'b1, AW'($urandom), 3 + int'($urandom % 14), 1, 2'b00,
              ($urandom % 3 == 0) ? 1 : -10, "R2 R5 R6 rand");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule